// File: doc/BRIEF.md
# Sequential Full-Chip Erase Sequencer

This block runs a whole-device erase one block at a time. A command port accepts byte-wide command writes. An erase starts only when the chip-erase setup code is written and the confirm code is the very next write. The sequencer then walks block indices upward from 0 to the last block. It passes over every block whose lock input is set. For each unlocked block it raises an erase request to a separate block-erase engine and holds it until that engine answers with a done pulse, which may come with a fail flag.

A failing block does not stop the run. Its flag is set in a per-block failure map, the sticky erase-error status bit is set, and the walk goes on with the next block. After a block finishes, the request stays low for one cycle before the next block is requested. The read port shows one of two views. The status view holds the ready bit, the erase-error bit and the sequence-error bit. The identify view shows the failure flag of the block selected by the read address. Starting an erase selects the status view, and it stays selected until a new command is written once the device is idle.

Top module: `chip_erase_seq`

## Requirements
- R1: An erase starts only when the setup code 0x30 is accepted and the next accepted write is the confirm code 0xD0. `ready` goes low in the cycle after the confirm write. A confirm written without a setup first starts nothing.
- R2: If the write that follows 0x30 is any code other than 0xD0, no erase starts and both the sequence-error bit (status bit 4) and the erase-error bit (status bit 5) are set.
- R3: Requests cover the unlocked blocks in strictly ascending order, starting at 0 and ending at NUM_BLOCKS-1. While `ers_req` is high and `eng_done` is low, `ers_req` stays high and `ers_blk` does not change.
- R4: A block whose `lock_bits` bit is 1 is never requested.
- R5: A done pulse with `eng_fail` high sets the failure flag of that block and sets status bit 5. The walk then continues with the next block.
- R6: `ready` (status bit 7) stays low from the confirm until the cycle after the last block's done. If every block is locked, `ready` is low for exactly one cycle.
- R7: After each done pulse, `ers_req` stays low for exactly one cycle before the next block is requested.
- R8: After a start, and also after the walk completes, `rd_data` shows the status byte: bit 7 ready, bit 5 erase error, bit 4 sequence error, all other bits 0. Code 0x90 selects the identify view, where `rd_data` is {7'b0, failure flag of block `rd_addr`}. Code 0x70 selects the status view again.
- R9: Every command written while `ready` is low has no effect.
- R10: All failure flags are cleared when a new erase starts.
- R11: Code 0x50, written while idle, clears status bits 5 and 4.
- R12: After reset, `ready`=1, `ers_req`=0, the status view is selected with `rd_data`=0x80, and every failure flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command write strobe, one cycle per write |
| cmd_code | input | 8 | Command byte |
| lock_bits | input | NUM_BLOCKS | Per-block lock state, 1 means locked |
| rd_addr | input | $clog2(NUM_BLOCKS) | Block index for the identify view |
| rd_data | output | 8 | Status byte or identify data |
| ready | output | 1 | High when no erase is running |
| ers_req | output | 1 | Erase request to the block engine |
| ers_blk | output | $clog2(NUM_BLOCKS) | Block being erased |
| eng_done | input | 1 | Engine finished the requested block |
| eng_fail | input | 1 | Qualifies eng_done: the block failed |

## Verification
If the block pointer is corrupted, the fault appears on `ers_blk` at the next request. The result is an out-of-order, repeated or locked index, seen within the one-cycle gap after a done pulse. If the walk state goes wrong, the request gap changes length or `ready` rises early or late, and this can be seen in the cycle where it happens. A failure-map or status fault stays hidden until the run finishes. It then shows in the identify view of each block and in bits 5 and 4 of the status byte.

// File: rtl/cfs_pkg.sv
`timescale 1ns/100ps
package cfs_pkg;

    localparam logic [7:0] OP_CHIP_SETUP = 8'h30;
    localparam logic [7:0] OP_CONFIRM    = 8'hD0;
    localparam logic [7:0] OP_READ_ID    = 8'h90;
    localparam logic [7:0] OP_READ_STAT  = 8'h70;
    localparam logic [7:0] OP_CLR_STAT   = 8'h50;

    typedef enum logic [1:0] {
        WALK_IDLE  = 2'd0,
        WALK_PICK  = 2'd1,
        WALK_ERASE = 2'd2
    } walk_state_e;

    typedef enum logic {
        VIEW_STATUS = 1'b0,
        VIEW_IDENT  = 1'b1
    } view_e;

    typedef struct packed {
        logic ready;
        logic erase_err;
        logic seq_err;
    } stat_t;

    // ready at bit 7, erase error at bit 5, sequence error at bit 4
    function automatic logic [7:0] pack_status(stat_t s);
        return {s.ready, 1'b0, s.erase_err, s.seq_err, 4'b0000};
    endfunction

endpackage

// File: rtl/cfs_cmd_decode.sv
`timescale 1ns/100ps
module cfs_cmd_decode
    import cfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    input  logic       busy,
    input  logic       set_erase_err,
    output logic       start,
    output view_e      view,
    output logic       erase_err,
    output logic       seq_err
);

    logic armed;
    logic accept;

    // Commands are taken only while the walker is idle
    assign accept = cmd_valid && !busy;
    assign start  = accept && armed && (cmd_code == OP_CONFIRM);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed     <= 1'b0;
            view      <= VIEW_STATUS;
            erase_err <= 1'b0;
            seq_err   <= 1'b0;
        end else begin
            if (set_erase_err) begin
                erase_err <= 1'b1;
            end
            if (accept) begin
                if (armed) begin
                    armed <= 1'b0;
                    view  <= VIEW_STATUS;
                    if (cmd_code != OP_CONFIRM) begin
                        erase_err <= 1'b1;
                        seq_err   <= 1'b1;
                    end
                end else begin
                    case (cmd_code)
                        OP_CHIP_SETUP: begin
                            armed <= 1'b1;
                            view  <= VIEW_STATUS;
                        end
                        OP_READ_ID:   view <= VIEW_IDENT;
                        OP_READ_STAT: view <= VIEW_STATUS;
                        OP_CLR_STAT: begin
                            erase_err <= 1'b0;
                            seq_err   <= 1'b0;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/cfs_walker.sv
`timescale 1ns/100ps
module cfs_walker
    import cfs_pkg::*;
#(
    parameter int NUM_BLOCKS = 32,
    localparam int BW = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [NUM_BLOCKS-1:0] lock_bits,
    input  logic                  eng_done,
    input  logic                  eng_fail,
    output logic                  busy,
    output logic                  ers_req,
    output logic [BW-1:0]         ers_blk,
    output logic                  fail_set,
    output logic [BW-1:0]         fail_idx
);

    localparam logic [BW-1:0] LAST_BLK = BW'(NUM_BLOCKS - 1);

    walk_state_e   state;
    logic [BW-1:0] cur;
    logic          hit;
    logic [BW-1:0] hit_idx;

    // Lowest unlocked block at or above the pointer
    always_comb begin
        hit     = 1'b0;
        hit_idx = cur;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            if (!hit && (i >= int'(cur)) && !lock_bits[i]) begin
                hit     = 1'b1;
                hit_idx = BW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WALK_IDLE;
            cur   <= '0;
        end else begin
            case (state)
                WALK_IDLE: begin
                    if (start) begin
                        state <= WALK_PICK;
                        cur   <= '0;
                    end
                end
                WALK_PICK: begin
                    if (hit) begin
                        cur   <= hit_idx;
                        state <= WALK_ERASE;
                    end else begin
                        state <= WALK_IDLE;
                    end
                end
                WALK_ERASE: begin
                    if (eng_done) begin
                        if (cur == LAST_BLK) begin
                            state <= WALK_IDLE;
                        end else begin
                            cur   <= cur + BW'(1);
                            state <= WALK_PICK;
                        end
                    end
                end
                default: state <= WALK_IDLE;
            endcase
        end
    end

    assign busy     = (state != WALK_IDLE);
    assign ers_req  = (state == WALK_ERASE);
    assign ers_blk  = cur;
    assign fail_set = ers_req && eng_done && eng_fail;
    assign fail_idx = cur;

endmodule

// File: rtl/cfs_fail_map.sv
`timescale 1ns/100ps
module cfs_fail_map #(
    parameter int NUM_BLOCKS = 32,
    localparam int BW = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clear,
    input  logic                  set,
    input  logic [BW-1:0]         set_idx,
    input  logic [BW-1:0]         rd_addr,
    output logic                  rd_bit,
    output logic [NUM_BLOCKS-1:0] map
);

    for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                map[g] <= 1'b0;
            end else if (set && (set_idx == BW'(g))) begin
                map[g] <= 1'b1;
            end
        end
    end

    assign rd_bit = map[rd_addr];

endmodule

// File: rtl/chip_erase_seq.sv
`timescale 1ns/100ps
module chip_erase_seq
    import cfs_pkg::*;
#(
    parameter int NUM_BLOCKS = 32,
    localparam int BW = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_valid,
    input  logic [7:0]            cmd_code,
    input  logic [NUM_BLOCKS-1:0] lock_bits,
    input  logic [BW-1:0]         rd_addr,
    output logic [7:0]            rd_data,
    output logic                  ready,
    output logic                  ers_req,
    output logic [BW-1:0]         ers_blk,
    input  logic                  eng_done,
    input  logic                  eng_fail
);

    logic                  busy;
    logic                  start;
    view_e                 view;
    logic                  erase_err_w;
    logic                  seq_err_w;
    logic                  fail_set;
    logic [BW-1:0]         fail_idx;
    logic                  id_bit;
    logic [NUM_BLOCKS-1:0] fail_map_w;
    stat_t                 stat;

    cfs_cmd_decode u_dec (
        .clk           (clk),
        .rst           (rst),
        .cmd_valid     (cmd_valid),
        .cmd_code      (cmd_code),
        .busy          (busy),
        .set_erase_err (fail_set),
        .start         (start),
        .view          (view),
        .erase_err     (erase_err_w),
        .seq_err       (seq_err_w)
    );

    cfs_walker #(.NUM_BLOCKS(NUM_BLOCKS)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .lock_bits (lock_bits),
        .eng_done  (eng_done),
        .eng_fail  (eng_fail),
        .busy      (busy),
        .ers_req   (ers_req),
        .ers_blk   (ers_blk),
        .fail_set  (fail_set),
        .fail_idx  (fail_idx)
    );

    cfs_fail_map #(.NUM_BLOCKS(NUM_BLOCKS)) u_map (
        .clk     (clk),
        .rst     (rst),
        .clear   (start),
        .set     (fail_set),
        .set_idx (fail_idx),
        .rd_addr (rd_addr),
        .rd_bit  (id_bit),
        .map     (fail_map_w)
    );

    always_comb begin
        stat.ready     = !busy;
        stat.erase_err = erase_err_w;
        stat.seq_err   = seq_err_w;
    end

    assign ready   = !busy;
    assign rd_data = (view == VIEW_STATUS) ? pack_status(stat) : {7'b0, id_bit};

endmodule

// File: rtl/chip_erase_seq_chk.sv
`timescale 1ns/100ps
module chip_erase_seq_chk
    import cfs_pkg::*;
#(
    parameter int NUM_BLOCKS = 32,
    localparam int BW = $clog2(NUM_BLOCKS)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cmd_valid,
    input logic [7:0]            cmd_code,
    input logic [NUM_BLOCKS-1:0] lock_bits,
    input logic                  ready,
    input logic                  ers_req,
    input logic [BW-1:0]         ers_blk,
    input logic                  eng_done,
    input logic                  eng_fail,
    input logic [NUM_BLOCKS-1:0] fail_map,
    input logic                  erase_err
);

    logic          seen;
    logic [BW-1:0] last_blk;

    always_ff @(posedge clk) begin
        if (rst || ready) begin
            seen     <= 1'b0;
            last_blk <= '0;
        end else if (ers_req) begin
            seen     <= 1'b1;
            last_blk <= ers_blk;
        end
    end

    p_start_confirm_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> ($past(cmd_valid) && ($past(cmd_code) == OP_CONFIRM)));

    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ers_req && !eng_done) |=> (ers_req && $stable(ers_blk)));

    p_ascending_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(ers_req) && seen) |-> (ers_blk > last_blk));

    p_no_locked_r4: assert property (@(posedge clk) disable iff (rst)
        ers_req |-> !lock_bits[ers_blk]);

    p_fail_flag_r5: assert property (@(posedge clk) disable iff (rst)
        (ers_req && eng_done && eng_fail) |=> (fail_map[$past(ers_blk)] && erase_err));

    p_busy_r6: assert property (@(posedge clk) disable iff (rst)
        ers_req |-> !ready);

    p_gap_r7: assert property (@(posedge clk) disable iff (rst)
        (ers_req && eng_done) |=> !ers_req);

    p_map_cleared_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(ready) |-> (fail_map == '0));

endmodule

bind chip_erase_seq chip_erase_seq_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .lock_bits (lock_bits),
    .ready     (ready),
    .ers_req   (ers_req),
    .ers_blk   (ers_blk),
    .eng_done  (eng_done),
    .eng_fail  (eng_fail),
    .fail_map  (fail_map_w),
    .erase_err (erase_err_w)
);

// File: tb/sim_chip_erase_seq.sv
`timescale 1ns/100ps
module sim_chip_erase_seq;
    import cfs_pkg::*;

    localparam int NB = 32;
    localparam int BW = $clog2(NB);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [7:0]    cmd_code = 8'h00;
    logic [NB-1:0] lock_bits = '0;
    logic [BW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          ready;
    logic          ers_req;
    logic [BW-1:0] ers_blk;
    logic          eng_done = 1'b0;
    logic          eng_fail = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    logic [NB-1:0] fail_plan = '0;
    int  req_log [NB];
    int  req_n = 0;
    bit  after_done = 1'b0;
    int  gap_cnt = 0;
    bit  exp_e5 = 1'b0;
    bit  exp_e4 = 1'b0;

    always #2.5 clk = ~clk;

    chip_erase_seq #(.NUM_BLOCKS(NB)) u0 (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .lock_bits (lock_bits),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .ready     (ready),
        .ers_req   (ers_req),
        .ers_blk   (ers_blk),
        .eng_done  (eng_done),
        .eng_fail  (eng_fail)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] stat_byte(input bit rdy, input bit e5, input bit e4);
        return {rdy, 1'b0, e5, e4, 4'b0000};
    endfunction

    // Caller is at a negative edge; returns at the next one
    task automatic send(input logic [7:0] c);
        cmd_valid = 1'b1;
        cmd_code  = c;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_code  = 8'h00;
    endtask

    // Engine stub and request monitor, all work at negative edges
    initial begin
        bit       prev_req = 1'b0;
        logic [BW-1:0] prev_blk = '0;
        int       wait_cnt = 0;
        int       delay = 0;
        forever begin
            @(negedge clk);
            if (eng_done) begin
                eng_done   = 1'b0;
                eng_fail   = 1'b0;
                after_done = 1'b1;
                gap_cnt    = 0;
            end
            if (ers_req && (!prev_req || after_done)) begin
                if (req_n < NB) req_log[req_n] = int'(ers_blk);
                req_n++;
                chk(!lock_bits[ers_blk], "R4 locked block requested", ers_blk, 0);
                if (after_done) chk(gap_cnt == 1, "R7 request gap", gap_cnt, 1);
                after_done = 1'b0;
                wait_cnt   = 0;
                delay      = int'($urandom % 4);
            end else if (ers_req) begin
                if (ers_blk != prev_blk)
                    chk(1'b0, "R3 block changed while requested", ers_blk, prev_blk);
            end else if (after_done) begin
                gap_cnt++;
            end
            if (ers_req && !after_done) begin
                if (wait_cnt >= delay) begin
                    eng_done = 1'b1;
                    eng_fail = fail_plan[ers_blk];
                end else begin
                    wait_cnt++;
                end
            end
            prev_req = ers_req;
            prev_blk = ers_blk;
        end
    end

    task automatic check_map(input logic [NB-1:0] exp_map, input string tag);
        send(OP_READ_ID);
        for (int i = 0; i < NB; i++) begin
            rd_addr = BW'(i);
            #0.1;
            chk(rd_data == {7'b0, exp_map[i]}, tag, rd_data, {7'b0, exp_map[i]});
        end
        @(negedge clk);
        send(OP_READ_STAT);
    endtask

    task automatic run_op(input logic [NB-1:0] lk, input logic [NB-1:0] fl, input bit poke);
        int exp_list [NB];
        int exp_n = 0;
        int waitc = 0;
        bit ok = 1'b1;
        logic [NB-1:0] exp_map;
        lock_bits  = lk;
        fail_plan  = fl;
        req_n      = 0;
        after_done = 1'b0;
        exp_map    = fl & ~lk;
        for (int i = 0; i < NB; i++) begin
            if (!lk[i]) begin
                exp_list[exp_n] = i;
                exp_n++;
            end
        end
        send(OP_CHIP_SETUP);
        send(OP_CONFIRM);
        chk(ready == 1'b0, "R1 ready low after confirm", ready, 0);
        if (poke) begin
            // R9: identify and clear written mid-run are dropped
            send(OP_READ_ID);
            send(OP_CLR_STAT);
            chk(rd_data == stat_byte(1'b0, exp_e5, exp_e4), "R9 R8 status view during run",
                rd_data, stat_byte(1'b0, exp_e5, exp_e4));
        end
        if (exp_n == 0) begin
            @(negedge clk);
            chk(ready == 1'b1, "R6 all locked one busy cycle", ready, 1);
        end
        while (!ready && waitc < 5000) begin
            @(negedge clk);
            waitc++;
        end
        chk(ready == 1'b1, "R6 run completes", ready, 1);
        if (exp_map != '0) exp_e5 = 1'b1;
        chk(rd_data == stat_byte(1'b1, exp_e5, exp_e4), "R8 R5 status after run",
            rd_data, stat_byte(1'b1, exp_e5, exp_e4));
        chk(req_n == exp_n, "R4 request count", req_n, exp_n);
        for (int i = 0; i < exp_n && i < req_n; i++) begin
            if (req_log[i] != exp_list[i]) ok = 1'b0;
        end
        chk(ok, "R3 ascending order", req_n, exp_n);
        check_map(exp_map, "R5 R10 failure flag");
    endtask

    initial begin
        int guard = 0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        chk(ready == 1'b1, "R12 ready after reset", ready, 1);
        chk(ers_req == 1'b0, "R12 no request after reset", ers_req, 0);
        chk(rd_data == 8'h80, "R12 status after reset", rd_data, 8'h80);
        check_map('0, "R12 map clear after reset");

        // R1: confirm alone does nothing
        send(OP_CONFIRM);
        repeat (3) begin
            chk(ready == 1'b1 && ers_req == 1'b0, "R1 confirm without setup", ready, 1);
            @(negedge clk);
        end

        // R2: setup followed by a non-confirm code
        send(OP_CHIP_SETUP);
        send(OP_READ_STAT);
        exp_e5 = 1'b1;
        exp_e4 = 1'b1;
        repeat (3) @(negedge clk);
        chk(ready == 1'b1 && ers_req == 1'b0, "R2 no run after bad sequence", ready, 1);
        chk(rd_data == 8'hB0, "R2 error bits set", rd_data, 8'hB0);

        // R9: commands written while busy are ignored
        run_op('0, '0, 1'b1);

        // R11: clear while idle
        send(OP_CLR_STAT);
        exp_e5 = 1'b0;
        exp_e4 = 1'b0;
        chk(rd_data == 8'h80, "R11 clear status", rd_data, 8'h80);

        // Directed: mixed locks and failures, including block 0 and last
        run_op(32'h0000_00F0, 32'h8000_0041, 1'b0);
        // R10: next run without failures clears the map
        run_op(32'h0F00_0000, '0, 1'b0);
        // All locked
        run_op('1, '0, 1'b0);
        // Only the last block unlocked, and it fails
        send(OP_CLR_STAT);
        exp_e5 = 1'b0;
        run_op({1'b0, {(NB-1){1'b1}}}, {1'b1, {(NB-1){1'b0}}}, 1'b0);
        // Only block 0 unlocked
        run_op({{(NB-1){1'b1}}, 1'b0}, '0, 1'b0);

        // Random mixes
        for (int r = 0; r < 8; r++) begin
            logic [NB-1:0] lk;
            logic [NB-1:0] fl;
            lk = NB'($urandom) & NB'($urandom);
            fl = NB'($urandom) & NB'($urandom) & NB'($urandom);
            send(OP_CLR_STAT);
            exp_e5 = 1'b0;
            exp_e4 = 1'b0;
            chk(rd_data == 8'h80, "R11 clear before random run", rd_data, 8'h80);
            run_op(lk, fl, 1'b0);
            guard++;
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule